// File: doc/BRIEF.md
# Software-Refilled Two-Way Translation Buffer

This block translates 40-bit virtual addresses into 36-bit physical addresses for 16 KB pages. It keeps 256 sets of two ways each. A lookup gives its result in the same cycle as the request: a hit with the translated address, a miss, or a protection fault. The lookup is checked against the stored entries, the access type (read or write) and the privilege level (user or kernel).

A miss is only reported. The block never walks a page table. Privileged software answers the miss by writing the translation into a set and way of its own choice through the refill port, then retries the access. The block keeps one least-recently-used bit per set and shows it on every lookup, so software can use that bit as the victim choice.

Each entry holds a dirty bit and a reference bit. The block sets the dirty bit on a write hit and the reference bit on any hit. Software can clear every reference bit in one cycle, and later read them back through lookups to see which pages have been used.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, so any valid lookup reports a miss. The victim hint of every set is 0.
- R2: The address splits as offset = vaddr[13:0], set = vaddr[21:14] and tag = vaddr[39:22]. A hit returns paddr = {stored 22-bit page number, vaddr[13:0]} in the request cycle. If both ways match, way 0 is used.
- R3: When no valid entry in the selected set has a matching tag, the block reports a miss with paddr 0. A miss changes no entry and no victim hint.
- R4: The rights codes are 0 = no access, 1 = read only, 2 = read/write, 3 = read/write in kernel mode only. A matching access that its rights do not allow reports a fault instead of a hit.
- R5: A fault gives paddr 0 and leaves the entry's dirty and reference bits and the set's victim hint unchanged.
- R6: A write hit sets the entry's dirty bit. lk_dirty shows the matching entry's stored dirty bit as it was before this access. A refill loads the dirty bit from rf_dirty.
- R7: Any hit sets the entry's reference bit, and lk_ref shows the stored value from before this access. A refill clears the reference bit. A pulse on ref_clear clears every reference bit, and this wins over a hit in the same cycle.
- R8: lk_victim is the victim hint of the looked-up set. A hit on way w, or a refill into way w, sets that set's hint to the other way.
- R9: A refill writes its entry at the clock edge. In a refill cycle the lookup reports no hit, miss or fault and updates nothing.
- R10: With lk_valid low, hit, miss and fault are all 0. At most one of the three is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 40 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| lk_paddr | output | 36 | Physical address on a hit, 0 otherwise |
| lk_hit | output | 1 | Translation found and allowed |
| lk_miss | output | 1 | No translation: trap for a software refill |
| lk_fault | output | 1 | Translation found but the access is not allowed |
| lk_dirty | output | 1 | Stored dirty bit of the matching entry (hit or fault) |
| lk_ref | output | 1 | Stored reference bit of the matching entry (hit or fault) |
| lk_victim | output | 1 | Victim hint of the looked-up set |
| rf_we | input | 1 | Refill write strobe |
| rf_set | input | 8 | Set to write |
| rf_way | input | 1 | Way to write |
| rf_valid | input | 1 | Valid bit to store |
| rf_dirty | input | 1 | Dirty bit to store |
| rf_rights | input | 2 | Rights code to store |
| rf_tag | input | 18 | Tag to store |
| rf_ppn | input | 22 | Physical page number to store |
| ref_clear | input | 1 | Clear all reference bits |

## Verification
A wrong tag, valid bit or page number would show at once, on the next lookup of that address, as a hit that should be a miss or as a wrong lk_paddr. Lost or stray dirty and reference updates are hidden until the same entry is looked up again. For that reason each such update is followed right away by a second lookup that reads lk_dirty or lk_ref. A wrong victim hint shows on lk_victim the next time the same set is presented, so the hint is checked after each hit, miss, fault and refill. A lookup that should have been ignored during a refill shows only through its missing side effects, which are also read back by a later lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    RIGHTS_NONE = 2'd0,
    RIGHTS_RO   = 2'd1,
    RIGHTS_RW   = 2'd2,
    RIGHTS_KRW  = 2'd3
  } rights_e;

  function automatic logic rights_allow(input logic [1:0] r, input logic wr, input logic kern);
    case (rights_e'(r))
      RIGHTS_NONE: return 1'b0;
      RIGHTS_RO:   return !wr;
      RIGHTS_RW:   return 1'b1;
      default:     return kern;
    endcase
  endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int SET_W = 8,
  parameter int TAG_W = 18,
  parameter int PPN_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_idx,
  input  logic             mark_dirty,
  input  logic             mark_ref,
  input  logic             clr_ref,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [1:0]       wr_rights,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic             rd_ref,
  output logic [1:0]       rd_rights,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PPN_W-1:0] rd_ppn
);
  localparam int SETS  = 1 << SET_W;
  localparam int PAY_W = 2 + TAG_W + PPN_W;

  logic [PAY_W-1:0] payload_q [SETS];
  logic [SETS-1:0]  valid_q, dirty_q, ref_q;

  // Payload is written only by refill: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) payload_q[wr_idx] <= {wr_rights, wr_tag, wr_ppn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end else if (mark_dirty) begin
      dirty_q[lk_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_ref) ref_q <= '0;
    else if (wr_en)     ref_q[wr_idx] <= 1'b0;
    else if (mark_ref)  ref_q[lk_idx] <= 1'b1;
  end

  assign {rd_rights, rd_tag, rd_ppn} = payload_q[lk_idx];
  assign rd_valid = valid_q[lk_idx];
  assign rd_dirty = dirty_q[lk_idx];
  assign rd_ref   = ref_q[lk_idx];

  // R7: a clear leaves no reference bit set
  p_ref_clear_r7: assert property (@(posedge clk) disable iff (rst) clr_ref |=> (ref_q == '0));
  // R6: a write mark leaves the entry dirty unless a refill overrides it
  p_dirty_mark_r6: assert property (@(posedge clk) disable iff (rst)
    (mark_dirty && !wr_en) |=> dirty_q[$past(lk_idx)]);
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_idx,
  input  logic             hit_en,
  input  logic             hit_way,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  logic             wr_way,
  output logic             victim
);
  localparam int SETS = 1 << SET_W;
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst)         lru_q <= '0;
    else if (wr_en)  lru_q[wr_idx] <= ~wr_way;
    else if (hit_en) lru_q[lk_idx] <= ~hit_way;
  end

  assign victim = lru_q[lk_idx];

  // R8: after a hit the hint points away from the used way
  p_lru_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (hit_en && !wr_en) |=> (lru_q[$past(lk_idx)] == ~$past(hit_way)));
  // R8: after a refill the hint points away from the written way
  p_lru_refill_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (lru_q[$past(wr_idx)] == ~$past(wr_way)));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int SET_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          lk_valid,
  input  logic [VA_W-1:0]               lk_vaddr,
  input  logic                          lk_write,
  input  logic                          lk_kernel,
  output logic [PA_W-1:0]               lk_paddr,
  output logic                          lk_hit,
  output logic                          lk_miss,
  output logic                          lk_fault,
  output logic                          lk_dirty,
  output logic                          lk_ref,
  output logic                          lk_victim,
  input  logic                          rf_we,
  input  logic [SET_W-1:0]              rf_set,
  input  logic                          rf_way,
  input  logic                          rf_valid,
  input  logic                          rf_dirty,
  input  logic [1:0]                    rf_rights,
  input  logic [VA_W-OFF_W-SET_W-1:0]   rf_tag,
  input  logic [PA_W-OFF_W-1:0]         rf_ppn,
  input  logic                          ref_clear
);
  import tlb_pkg::*;

  localparam int WAYS  = 2;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [SET_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [OFF_W-1:0] lk_off;
  assign lk_off = lk_vaddr[OFF_W-1:0];
  assign lk_idx = lk_vaddr[OFF_W+SET_W-1:OFF_W];
  assign lk_tag = lk_vaddr[VA_W-1:OFF_W+SET_W];

  logic [WAYS-1:0]  w_valid, w_dirty, w_ref, match, mark_dirty, mark_ref, wr_en;
  logic [1:0]       w_rights [WAYS];
  logic [TAG_W-1:0] w_tag    [WAYS];
  logic [PPN_W-1:0] w_ppn    [WAYS];

  logic active, any, hit_way, allowed;

  assign active  = lk_valid && !rf_we;
  assign any     = |match;
  assign hit_way = !match[0];
  assign allowed = rights_allow(w_rights[hit_way], lk_write, lk_kernel);

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      assign match[w]      = w_valid[w] && (w_tag[w] == lk_tag);
      assign wr_en[w]      = rf_we && (rf_way == 1'(w));
      assign mark_ref[w]   = lk_hit && (hit_way == 1'(w));
      assign mark_dirty[w] = mark_ref[w] && lk_write;

      tlb_way #(.SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_way (
        .clk        (clk),
        .rst        (rst),
        .lk_idx     (lk_idx),
        .mark_dirty (mark_dirty[w]),
        .mark_ref   (mark_ref[w]),
        .clr_ref    (ref_clear),
        .wr_en      (wr_en[w]),
        .wr_idx     (rf_set),
        .wr_valid   (rf_valid),
        .wr_dirty   (rf_dirty),
        .wr_rights  (rf_rights),
        .wr_tag     (rf_tag),
        .wr_ppn     (rf_ppn),
        .rd_valid   (w_valid[w]),
        .rd_dirty   (w_dirty[w]),
        .rd_ref     (w_ref[w]),
        .rd_rights  (w_rights[w]),
        .rd_tag     (w_tag[w]),
        .rd_ppn     (w_ppn[w])
      );
    end
  endgenerate

  tlb_lru #(.SET_W(SET_W)) u_lru (
    .clk     (clk),
    .rst     (rst),
    .lk_idx  (lk_idx),
    .hit_en  (lk_hit),
    .hit_way (hit_way),
    .wr_en   (rf_we),
    .wr_idx  (rf_set),
    .wr_way  (rf_way),
    .victim  (lk_victim)
  );

  always_comb begin
    lk_hit   = active && any && allowed;
    lk_fault = active && any && !allowed;
    lk_miss  = active && !any;
    lk_dirty = (active && any) ? w_dirty[hit_way] : 1'b0;
    lk_ref   = (active && any) ? w_ref[hit_way]   : 1'b0;
    lk_paddr = lk_hit ? {w_ppn[hit_way], lk_off} : '0;
  end

  // R10: outcomes are exclusive
  p_excl_r10: assert property (@(posedge clk) disable iff (rst) $onehot0({lk_hit, lk_miss, lk_fault}));
  // R10: nothing reported without a request
  p_idle_r10: assert property (@(posedge clk) disable iff (rst) !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
  // R9: refill cycle hides the lookup
  p_refill_quiet_r9: assert property (@(posedge clk) disable iff (rst) rf_we |-> !(lk_hit || lk_miss || lk_fault));
  // R2: page offset passes through untranslated
  p_offset_r2: assert property (@(posedge clk) disable iff (rst) lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  // R5: a fault gives no address
  p_fault_addr_r5: assert property (@(posedge clk) disable iff (rst) lk_fault |-> (lk_paddr == '0));
endmodule

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid = 0, lk_write = 0, lk_kernel = 0;
  logic [39:0] lk_vaddr = '0;
  logic [35:0] lk_paddr;
  logic        lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref, lk_victim;
  logic        rf_we = 0, rf_way = 0, rf_valid = 0, rf_dirty = 0, ref_clear = 0;
  logic [7:0]  rf_set = '0;
  logic [1:0]  rf_rights = '0;
  logic [17:0] rf_tag = '0;
  logic [21:0] rf_ppn = '0;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  xlat_tlb dut_i (.*);

  function automatic logic [39:0] mk_va(input logic [17:0] t, input logic [7:0] s, input logic [13:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic refill(input logic [7:0] s, input logic wy, input logic [17:0] t,
                        input logic [21:0] p, input logic [1:0] r, input logic d, input logic v);
    @(negedge clk);
    rf_we = 1; rf_set = s; rf_way = wy; rf_tag = t; rf_ppn = p;
    rf_rights = r; rf_dirty = d; rf_valid = v;
    @(posedge clk); #1;
    rf_we = 0;
  endtask

  // Drive at negedge, sample 1 ns later, update applies at next posedge
  task automatic look(input logic [39:0] va, input logic wr, input logic kern);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_write = wr; lk_kernel = kern;
    #1;
  endtask

  task automatic look_end();
    @(posedge clk); #1;
    lk_valid = 0; lk_write = 0; lk_kernel = 0;
  endtask

  task automatic t_reset();
    look(mk_va(18'h00123, 8'd5, 14'h0011), 0, 1);
    chk("R1", "miss after reset", lk_miss, 1);
    chk("R1", "hit after reset", lk_hit, 0);
    chk("R1", "victim after reset", lk_victim, 0);
    chk("R3", "paddr on miss", lk_paddr, 0);
    look_end();
  endtask

  task automatic t_hit_lru();
    refill(8'd5, 0, 18'h2ABCD, 22'h15A5A5, 2'd2, 0, 1);
    look(mk_va(18'h2ABCD, 8'd5, 14'h1234), 0, 0);
    chk("R2", "hit way0", lk_hit, 1);
    chk("R2", "paddr way0", lk_paddr, {22'h15A5A5, 14'h1234});
    chk("R7", "ref before first hit", lk_ref, 0);
    chk("R8", "victim after refill way0", lk_victim, 1);
    look_end();
    look(mk_va(18'h2ABCD, 8'd5, 14'h3FFF), 0, 0);
    chk("R7", "ref after hit", lk_ref, 1);
    chk("R2", "paddr offset max", lk_paddr, {22'h15A5A5, 14'h3FFF});
    look_end();
    refill(8'd5, 1, 18'h01111, 22'h0C0C0C, 2'd2, 0, 1);
    look(mk_va(18'h01111, 8'd5, 14'h0000), 0, 0);
    chk("R2", "hit way1", lk_hit, 1);
    chk("R2", "paddr way1", lk_paddr, {22'h0C0C0C, 14'h0000});
    chk("R8", "victim after refill way1", lk_victim, 0);
    look_end();
    look(mk_va(18'h2ABCD, 8'd5, 14'h0001), 0, 0);
    chk("R8", "victim after hit way1", lk_victim, 0);
    look_end();
    look(mk_va(18'h01111, 8'd5, 14'h0001), 0, 0);
    chk("R8", "victim after hit way0", lk_victim, 1);
    look_end();
  endtask

  task automatic t_miss();
    look(mk_va(18'h3FFFF, 8'd5, 14'h0100), 0, 1);
    chk("R3", "tag mismatch misses", lk_miss, 1);
    chk("R3", "paddr zero", lk_paddr, 0);
    look_end();
    look(mk_va(18'h2ABCD, 8'd6, 14'h0100), 0, 1);
    chk("R3", "other set misses", lk_miss, 1);
    look_end();
    look(mk_va(18'h2ABCD, 8'd5, 14'h0100), 0, 0);
    chk("R3", "victim unchanged by miss", lk_victim, 0);
    look_end();
  endtask

  task automatic t_dirty();
    look(mk_va(18'h2ABCD, 8'd5, 14'h0040), 1, 0);
    chk("R6", "write hit", lk_hit, 1);
    chk("R6", "dirty before write", lk_dirty, 0);
    look_end();
    look(mk_va(18'h2ABCD, 8'd5, 14'h0040), 0, 0);
    chk("R6", "dirty after write", lk_dirty, 1);
    look_end();
    refill(8'd40, 0, 18'h00777, 22'h000777, 2'd2, 1, 1);
    look(mk_va(18'h00777, 8'd40, 14'h0000), 0, 0);
    chk("R6", "dirty from refill", lk_dirty, 1);
    look_end();
  endtask

  task automatic t_rights();
    refill(8'd9, 0, 18'h00009, 22'h000099, 2'd0, 0, 1);
    look(mk_va(18'h00009, 8'd9, 14'h0005), 0, 1);
    chk("R4", "no-access faults", lk_fault, 1);
    chk("R5", "fault paddr", lk_paddr, 0);
    look_end();
    refill(8'd9, 0, 18'h00009, 22'h000099, 2'd1, 0, 1);
    look(mk_va(18'h00009, 8'd9, 14'h0005), 1, 1);
    chk("R4", "write to read-only faults", lk_fault, 1);
    look_end();
    look(mk_va(18'h00009, 8'd9, 14'h0005), 1, 1);
    chk("R5", "dirty kept by fault", lk_dirty, 0);
    chk("R5", "ref kept by fault", lk_ref, 0);
    chk("R5", "victim kept by fault", lk_victim, 1);
    look_end();
    look(mk_va(18'h00009, 8'd9, 14'h0005), 0, 0);
    chk("R4", "read of read-only hits", lk_hit, 1);
    look_end();
    refill(8'd9, 1, 18'h00010, 22'h000100, 2'd3, 0, 1);
    look(mk_va(18'h00010, 8'd9, 14'h0000), 0, 0);
    chk("R4", "user on kernel page faults", lk_fault, 1);
    look_end();
    look(mk_va(18'h00010, 8'd9, 14'h0000), 1, 1);
    chk("R4", "kernel write on kernel page", lk_hit, 1);
    chk("R4", "kernel page paddr", lk_paddr, {22'h000100, 14'h0000});
    look_end();
  endtask

  task automatic t_ref_clear();
    look(mk_va(18'h2ABCD, 8'd5, 14'h0000), 0, 0);
    chk("R7", "ref set before clear", lk_ref, 1);
    ref_clear = 1;
    look_end();
    ref_clear = 0;
    look(mk_va(18'h2ABCD, 8'd5, 14'h0000), 0, 0);
    chk("R7", "clear wins over hit", lk_ref, 0);
    look_end();
    look(mk_va(18'h01111, 8'd5, 14'h0000), 0, 0);
    chk("R7", "other entry cleared", lk_ref, 0);
    look_end();
  endtask

  task automatic t_priority();
    refill(8'd20, 0, 18'h00020, 22'h000020, 2'd2, 0, 1);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = mk_va(18'h00020, 8'd20, 14'h0000); lk_write = 1;
    rf_we = 1; rf_set = 8'd30; rf_way = 1; rf_tag = 18'h00030; rf_ppn = 22'h000030;
    rf_rights = 2'd2; rf_dirty = 0; rf_valid = 1;
    #1;
    chk("R9", "outcomes hidden in refill cycle", {lk_hit, lk_miss, lk_fault}, 0);
    @(posedge clk); #1;
    rf_we = 0; lk_valid = 0; lk_write = 0;
    look(mk_va(18'h00020, 8'd20, 14'h0000), 0, 0);
    chk("R9", "no dirty from hidden lookup", lk_dirty, 0);
    chk("R9", "no ref from hidden lookup", lk_ref, 0);
    chk("R9", "no hint change from hidden lookup", lk_victim, 1);
    look_end();
    look(mk_va(18'h00030, 8'd30, 14'h0ABC), 0, 0);
    chk("R9", "refill landed", lk_paddr, {22'h000030, 14'h0ABC});
    look_end();
  endtask

  task automatic t_idle();
    @(negedge clk);
    lk_valid = 0; lk_vaddr = mk_va(18'h2ABCD, 8'd5, 14'h0000);
    #1;
    chk("R10", "idle outputs", {lk_hit, lk_miss, lk_fault}, 0);
    refill(8'd5, 0, 18'h2ABCD, 22'h15A5A5, 2'd2, 0, 0);
    look(mk_va(18'h2ABCD, 8'd5, 14'h0000), 0, 0);
    chk("R3", "invalidated entry misses", lk_miss, 1);
    look_end();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_hit_lru();
    t_miss();
    t_dirty();
    t_rights();
    t_ref_clear();
    t_priority();
    t_idle();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule